// File: doc/BRIEF.md
# PDM microphone output interface

This block is the digital back end of a pulse-density-modulated microphone. It runs on a fast system clock and oversamples an incoming microphone clock and a channel-select strap. Each microphone clock period, it puts one modulator bit onto a shared data wire. The block drives the wire during one half of the microphone clock period and releases it during the other half. The strap picks which half. Two devices with opposite straps can therefore share one clock and one data wire as a stereo pair. The block provides a data value and a separate output enable, and the tri-state pad sits outside it.

A rate detector measures the interval between rising edges of the microphone clock in system clock cycles. It wakes the block when the clock is fast enough and puts it to sleep when the clock is too slow or stops. Between the two thresholds, the current state is kept. After a wake-up, a settling interval counted in microphone clock cycles runs before the first drive window opens. The strap is captured only while asleep, so moving it during operation cannot make two devices drive at once.

Top module: `pdm_mic_if`

## Requirements
- R1: With the latched select at 0, the output enable rises after a falling edge of the microphone clock and falls after the next rising edge. The driven value is the modulator bit present at that falling edge.
- R2: With the latched select at 1, the enable rises after a rising edge and falls after the next falling edge. The driven value is the modulator bit present at that rising edge.
- R3: Two instances sharing the microphone clock with opposite select values never assert their enables in the same system clock cycle.
- R4: A rising-edge interval of at most floor(SYS_HZ/WAKE_HZ) system cycles is fast. With the defaults this is 166 cycles, about 300 kHz. WAKE_QUAL consecutive fast intervals wake a sleeping block. An interval of 167 cycles never wakes it.
- R5: When no rising edge arrives within ceil(SYS_HZ/SLEEP_HZ) system cycles, the block goes to sleep within two cycles. With the defaults this is 715 cycles, about 70 kHz. An interval of 714 cycles keeps an awake block awake.
- R6: Intervals strictly between the two limits leave the current state unchanged, whether asleep or awake.
- R7: After a wake is qualified, SETTLE_MCLK further rising edges are counted before the run state begins. Counting from the first edge after sleep, the run state starts at rising edge WAKE_QUAL+1+SETTLE_MCLK. No earlier drive window opens.
- R8: The output enable stays low during reset, while asleep and while settling.
- R9: The select strap is latched only while asleep. A change during settling or running has no effect on the drive phase until the next sleep.
- R10: While the enable is high, the data output stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mic_clk_i | input | 1 | Microphone clock, asynchronous to clk_i |
| edge_sel_i | input | 1 | Channel strap: 0 drives in the low half, 1 in the high half |
| mod_bit_i | input | 1 | Modulator bit for the current microphone clock period |
| pdm_data_o | output | 1 | Value for the data pad |
| pdm_oe_o | output | 1 | Enable for the data pad driver |

## Verification
The bench runs a left and a right instance on one clock and checks each drive window for phase and data, at 50% duty cycle and at both duty-cycle limits. A design that mixed up the edges would collide with its partner or send the wrong bit. The rate limits are probed exactly at 166/167 and 714/715 cycles. An off-by-one in the interval counter shows up as a wrong wake or a missed sleep. Hysteresis is checked at a 300-cycle period from both states, along with a stopped clock. The wake latency is checked to the exact microphone cycle. A strap change made while running must not move the drive phase until after the next sleep, and a design that sampled it continuously would flip phase and contend with its partner.

// File: rtl/pdm_mic_pkg.sv
package pdm_mic_pkg;

  typedef enum logic [1:0] {
    PWR_SLEEP  = 2'd0,
    PWR_SETTLE = 2'd1,
    PWR_RUN    = 2'd2
  } pwr_state_e;

  function automatic int unsigned div_ceil(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/pdm_sync.sv
// Multi-stage synchronizer for a group of asynchronous single-bit inputs.
module pdm_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) begin
        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/pdm_rate_det.sv
// Measures the microphone clock period in system cycles and decides
// awake/asleep with a hysteresis band between two period limits.
module pdm_rate_det #(
  parameter int unsigned WAKE_PERIOD  = 166,
  parameter int unsigned SLEEP_PERIOD = 715,
  parameter int unsigned WAKE_QUAL    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  output logic active_o,
  output logic slow_o
);

  localparam int unsigned CNT_W = $clog2(SLEEP_PERIOD + 1);

  logic [CNT_W-1:0] gap_q, gap_d;
  logic             active_q, active_d;
  logic             fast_edge;
  logic             wake_hit;

  // Gap counter: 1 in the cycle after a rising edge, saturates at the sleep limit.
  always_comb begin
    gap_d = gap_q;
    if (rise_i) begin
      gap_d = CNT_W'(1);
    end else if (gap_q < CNT_W'(SLEEP_PERIOD)) begin
      gap_d = gap_q + CNT_W'(1);
    end
  end

  assign slow_o    = (gap_q >= CNT_W'(SLEEP_PERIOD));
  assign fast_edge = rise_i && (gap_q <= CNT_W'(WAKE_PERIOD));

  generate
    if (WAKE_QUAL > 1) begin : g_qual
      localparam int unsigned QUAL_W = (WAKE_QUAL > 2) ? $clog2(WAKE_QUAL) : 1;
      logic [QUAL_W-1:0] qual_q, qual_d;

      always_comb begin
        qual_d = qual_q;
        if (slow_o || (rise_i && !fast_edge)) begin
          qual_d = '0;
        end else if (fast_edge && (qual_q != QUAL_W'(WAKE_QUAL - 1))) begin
          qual_d = qual_q + QUAL_W'(1);
        end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          qual_q <= '0;
        end else begin
          qual_q <= qual_d;
        end
      end

      assign wake_hit = fast_edge && (qual_q == QUAL_W'(WAKE_QUAL - 1));
    end else begin : g_noqual
      assign wake_hit = fast_edge;
    end
  endgenerate

  always_comb begin
    active_d = active_q;
    if (slow_o) begin
      active_d = 1'b0;
    end else if (wake_hit) begin
      active_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q    <= CNT_W'(SLEEP_PERIOD);
      active_q <= 1'b0;
    end else begin
      gap_q    <= gap_d;
      active_q <= active_d;
    end
  end

  assign active_o = active_q;

endmodule

// File: rtl/pdm_pwr_ctl.sv
// Sleep / settle / run sequencing and strap capture.
module pdm_pwr_ctl
  import pdm_mic_pkg::*;
#(
  parameter int unsigned SETTLE_MCLK = 840
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       active_i,
  input  logic       rise_i,
  input  logic       sel_sync_i,
  output pwr_state_e state_o,
  output logic       run_o,
  output logic       sel_o
);

  localparam int unsigned ST_W = (SETTLE_MCLK > 1) ? $clog2(SETTLE_MCLK) : 1;

  pwr_state_e      state_q, state_d;
  logic [ST_W-1:0] settle_q, settle_d;
  logic            sel_q;
  logic            sel_en;

  always_comb begin
    state_d  = state_q;
    settle_d = settle_q;
    unique case (state_q)
      PWR_SLEEP: begin
        settle_d = '0;
        if (active_i) begin
          state_d = PWR_SETTLE;
        end
      end
      PWR_SETTLE: begin
        if (!active_i) begin
          state_d = PWR_SLEEP;
        end else if (rise_i) begin
          if (settle_q == ST_W'(SETTLE_MCLK - 1)) begin
            state_d = PWR_RUN;
          end else begin
            settle_d = settle_q + ST_W'(1);
          end
        end
      end
      PWR_RUN: begin
        if (!active_i) begin
          state_d = PWR_SLEEP;
        end
      end
      default: begin
        state_d = PWR_SLEEP;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= PWR_SLEEP;
      settle_q <= '0;
    end else begin
      state_q  <= state_d;
      settle_q <= settle_d;
    end
  end

  // Strap captured only while asleep.
  assign sel_en = (state_q == PWR_SLEEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= 1'b0;
    end else if (sel_en) begin
      sel_q <= sel_sync_i;
    end
  end

  assign state_o = state_q;
  assign run_o   = (state_q == PWR_RUN);
  assign sel_o   = sel_q;

endmodule

// File: rtl/pdm_drive.sv
// Opens and closes the data drive window on the edges the strap selects.
module pdm_drive (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic sel_i,
  input  logic rise_i,
  input  logic fall_i,
  input  logic bit_i,
  output logic data_o,
  output logic oe_o
);

  logic oe_q, oe_d;
  logic data_q, data_d;
  logic open_edge, close_edge;

  assign open_edge  = sel_i ? rise_i : fall_i;
  assign close_edge = sel_i ? fall_i : rise_i;

  always_comb begin
    oe_d   = oe_q;
    data_d = data_q;
    if (!run_i) begin
      oe_d = 1'b0;
    end else if (open_edge) begin
      oe_d   = 1'b1;
      data_d = bit_i;
    end else if (close_edge) begin
      oe_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q   <= 1'b0;
      data_q <= 1'b0;
    end else begin
      oe_q   <= oe_d;
      data_q <= data_d;
    end
  end

  assign oe_o   = oe_q;
  assign data_o = data_q;

endmodule

// File: rtl/pdm_mic_if.sv
module pdm_mic_if
  import pdm_mic_pkg::*;
#(
  parameter int unsigned SYS_HZ      = 50_000_000,
  parameter int unsigned WAKE_HZ     = 300_000,
  parameter int unsigned SLEEP_HZ    = 70_000,
  parameter int unsigned WAKE_QUAL   = 2,
  parameter int unsigned SETTLE_MCLK = 840,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mic_clk_i,
  input  logic edge_sel_i,
  input  logic mod_bit_i,
  output logic pdm_data_o,
  output logic pdm_oe_o
);

  localparam int unsigned WAKE_PERIOD  = SYS_HZ / WAKE_HZ;
  localparam int unsigned SLEEP_PERIOD = div_ceil(SYS_HZ, SLEEP_HZ);

  logic       rst_meta_q, rst_q;
  logic [2:0] sync_q;
  logic       mclk_s, bit_s, sel_s;
  logic       mclk_d_q;
  logic       rise, fall;
  logic       active, slow;
  logic       run, sel_lat;
  pwr_state_e pwr_state;

  // Reset asserted asynchronously, released on the clock.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  // Clock and data synchronized together so the bit stays aligned with its edge.
  pdm_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_q),
    .d_i   ({edge_sel_i, mod_bit_i, mic_clk_i}),
    .q_o   (sync_q)
  );

  assign {sel_s, bit_s, mclk_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_q) begin
    if (!rst_q) begin
      mclk_d_q <= 1'b0;
    end else begin
      mclk_d_q <= mclk_s;
    end
  end

  assign rise = mclk_s & ~mclk_d_q;
  assign fall = ~mclk_s & mclk_d_q;

  pdm_rate_det #(
    .WAKE_PERIOD (WAKE_PERIOD),
    .SLEEP_PERIOD(SLEEP_PERIOD),
    .WAKE_QUAL   (WAKE_QUAL)
  ) u_rate (
    .clk_i   (clk_i),
    .rst_ni  (rst_q),
    .rise_i  (rise),
    .active_o(active),
    .slow_o  (slow)
  );

  pdm_pwr_ctl #(.SETTLE_MCLK(SETTLE_MCLK)) u_pwr (
    .clk_i     (clk_i),
    .rst_ni    (rst_q),
    .active_i  (active),
    .rise_i    (rise),
    .sel_sync_i(sel_s),
    .state_o   (pwr_state),
    .run_o     (run),
    .sel_o     (sel_lat)
  );

  pdm_drive u_drive (
    .clk_i (clk_i),
    .rst_ni(rst_q),
    .run_i (run),
    .sel_i (sel_lat),
    .rise_i(rise),
    .fall_i(fall),
    .bit_i (bit_s),
    .data_o(pdm_data_o),
    .oe_o  (pdm_oe_o)
  );

endmodule

// File: rtl/pdm_mic_if_chk.sv
module pdm_mic_if_chk
  import pdm_mic_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       oe_i,
  input logic       data_i,
  input logic       mclk_d_i,
  input logic       sel_i,
  input pwr_state_e state_i,
  input logic       slow_i
);

  AST_OE_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_i |-> (mclk_d_i == sel_i)); // R1 R2

  AST_QUIET_UNLESS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != PWR_RUN) |=> !oe_i); // R8

  AST_SEL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != PWR_SLEEP) |=> $stable(sel_i)); // R9

  AST_SLOW_SLEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_i |-> ##2 (state_i == PWR_SLEEP)); // R5

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_i && $past(oe_i)) |-> $stable(data_i)); // R10

endmodule

bind pdm_mic_if pdm_mic_if_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .oe_i    (pdm_oe_o),
  .data_i  (pdm_data_o),
  .mclk_d_i(mclk_d_q),
  .sel_i   (sel_lat),
  .state_i (pwr_state),
  .slow_i  (slow)
);

// File: tb/pdm_mic_if_tb_top.sv
`timescale 1ns/1ps
module pdm_mic_if_tb_top;

  localparam int SETTLE = 32;
  localparam int QUAL   = 2;
  localparam int WAKE_P = 50_000_000 / 300_000;            // 166
  localparam int SLEEP_P = (50_000_000 + 69_999) / 70_000; // 715
  localparam int FIRST_RUN = QUAL + 1 + SETTLE;            // 35

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mic_clk = 1'b0;
  logic mod_bit = 1'b0;
  logic sel_l = 1'b0;
  logic sel_r = 1'b1;
  logic exp_l = 1'b0;
  logic exp_r = 1'b1;
  logic d_l, oe_l, d_r, oe_r;
  logic [15:0] lfsr = 16'hACE1;

  int n_chk = 0;
  int n_fail = 0;
  int overlap = 0;

  always #10 clk = ~clk;

  pdm_mic_if #(.WAKE_QUAL(QUAL), .SETTLE_MCLK(SETTLE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mic_clk_i(mic_clk), .edge_sel_i(sel_l),
    .mod_bit_i(mod_bit), .pdm_data_o(d_l), .pdm_oe_o(oe_l));

  pdm_mic_if #(.WAKE_QUAL(QUAL), .SETTLE_MCLK(SETTLE)) dut_r (
    .clk_i(clk), .rst_ni(rst_n), .mic_clk_i(mic_clk), .edge_sel_i(sel_r),
    .mod_bit_i(mod_bit), .pdm_data_o(d_r), .pdm_oe_o(oe_r));

  always @(negedge clk) if (rst_n && oe_l && oe_r) overlap++;

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // mode 0: both quiet, 1: normal drive, 2: first run cycle (only low-half drivers open)
  task automatic judge(input string tag, input string side, input logic oe, input logic d,
                       input logic s, input logic hi, input logic b, input int mode);
    logic exp_oe;
    string req;
    if (mode == 0) exp_oe = 1'b0;
    else if (mode == 2 && hi) exp_oe = 1'b0;
    else exp_oe = (s == hi);
    if (tag != "") req = tag;
    else if (mode == 0) req = "R8";
    else if (mode == 2) req = "R7";
    else req = s ? "R2" : "R1";
    chk(req, {side, hi ? " oe high half" : " oe low half"}, oe, exp_oe);
    if (exp_oe) chk("R10", {side, " data"}, d, b);
  endtask

  task automatic mic_cycle(input int hi, input int lo, input logic b, input int mode, input string tag);
    mod_bit = b;
    mic_clk = 1'b1;
    repeat (hi) @(negedge clk);
    judge(tag, "left", oe_l, d_l, exp_l, 1'b1, b, mode);
    judge(tag, "right", oe_r, d_r, exp_r, 1'b1, b, mode);
    mic_clk = 1'b0;
    repeat (lo) @(negedge clk);
    judge(tag, "left", oe_l, d_l, exp_l, 1'b0, b, mode);
    judge(tag, "right", oe_r, d_r, exp_r, 1'b0, b, mode);
  endtask

  function automatic logic next_bit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic wake_seq(input int hi, input int lo, input string tag);
    for (int k = 1; k < FIRST_RUN; k++) mic_cycle(hi, lo, next_bit(), 0, tag);
    mic_cycle(hi, lo, next_bit(), 2, "R7");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8", "left oe in reset", oe_l, 1'b0);
    chk("R8", "right oe in reset", oe_r, 1'b0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // first wake at 2.5 MHz, exact settle latency
    wake_seq(10, 10, "");
    // data patterns, nominal and duty-cycle limits
    for (int k = 0; k < 30; k++) mic_cycle(10, 10, next_bit(), 1, "");
    for (int k = 0; k < 10; k++) mic_cycle(8, 12, next_bit(), 1, "");
    for (int k = 0; k < 10; k++) mic_cycle(12, 8, next_bit(), 1, "");
    for (int k = 0; k < 5; k++) mic_cycle(10, 10, 1'b1, 1, "");
    for (int k = 0; k < 5; k++) mic_cycle(10, 10, 1'b0, 1, "");

    // R6: awake, intermediate rate keeps running
    for (int k = 0; k < 5; k++) mic_cycle(150, 150, next_bit(), 1, "R6");
    // R5: 714-cycle period stays awake
    for (int k = 0; k < 3; k++) mic_cycle(357, 357, next_bit(), 1, "R5");
    // R5: 715-cycle period puts it to sleep
    mic_cycle(358, SLEEP_P - 358, next_bit(), 1, "R5");
    mic_cycle(358, SLEEP_P - 358, next_bit(), 0, "R5");
    mic_cycle(358, SLEEP_P - 358, next_bit(), 0, "R5");

    // wake again, then move the straps while running (R9)
    wake_seq(10, 10, "");
    sel_l = 1'b1;
    sel_r = 1'b0;
    for (int k = 0; k < 8; k++) mic_cycle(10, 10, next_bit(), 1, "R9");

    // R5: stopped clock times out
    mic_clk = 1'b0;
    repeat (SLEEP_P + 100) @(negedge clk);
    chk("R5", "left oe after stall", oe_l, 1'b0);
    chk("R5", "right oe after stall", oe_r, 1'b0);
    exp_l = 1'b1;
    exp_r = 1'b0;

    // R6: asleep, intermediate rate never wakes
    for (int k = 0; k < 20; k++) mic_cycle(150, 150, next_bit(), 0, "R6");
    // R4: 167-cycle period never wakes
    for (int k = 0; k < 40; k++) mic_cycle(84, WAKE_P + 1 - 84, next_bit(), 0, "R4");
    // R4: 166-cycle period wakes, new strap values in effect (R9)
    wake_seq(83, WAKE_P - 83, "R4");
    for (int k = 0; k < 4; k++) mic_cycle(83, WAKE_P - 83, next_bit(), 1, "R9");
    for (int k = 0; k < 10; k++) mic_cycle(10, 10, next_bit(), 1, "");

    chk("R3", "drive windows overlapped", overlap != 0, 1'b0);
    report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    report();
    $finish;
  end

endmodule